// File: doc/BRIEF.md
# GF(2^113) Pipelined Field Inverter

This block computes the multiplicative inverse of an element of GF(2^113) in polynomial basis. The field is defined by the reduction polynomial x^113 + x^5 + x^3 + x^2 + 1. The inverse is found by raising the element to the power 2^113 − 2. The exponentiation follows a fixed Itoh-Tsujii addition chain. Every multiplication and every squaring has its own hardware, so the run time does not depend on the data and a new element can enter on every clock.

The addition chain comes from the binary form of 112. It builds a^(2^k − 1) for k = 1, 2, 3, 6, 7, 14, 28, 56, 112. There are two kinds of chain step:
- A doubling step squares the running value k times and multiplies the result by a copy of that same value, delayed to match.
- An increment step squares once and multiplies by a delayed copy of the original element.

One final squaring gives a^(2^113 − 2). The chain uses 112 squaring stages of one cycle each and 8 multipliers of 7 cycles each. The total latency is therefore 168 cycles.

A valid bit travels through the pipeline alongside the data. No handshake exists and the pipeline never stalls. A zero input lies outside the function, but its valid bit still travels through normally.

Top module: `gf113_inverter`

## Requirements
- R1: After reset, out_valid stays low until a result from an accepted element reaches the output.
- R2: out_valid is high exactly 168 rising edges after the edge that captured an element with in_valid high, and it is low in every other cycle.
- R3: For a nonzero input, out_inv multiplied by in_elem equals 1 modulo x^113 + x^5 + x^3 + x^2 + 1. Bit i of each 113-bit vector is the coefficient of x^i.
- R4: An element is accepted on every clock. A back-to-back stream returns one result per clock, in input order, and the number of results equals the number of inputs.
- R5: The input value 1 returns the value 1.
- R6: Gaps in the input stream reappear at the output with the same spacing.
- R7: An all-zero input with in_valid high still produces out_valid 168 cycles later. Its data is unspecified.
- R8: The input x (value 2) returns x^112 + x^4 + x^2 + x.
- R9: Reset discards every element in flight. After reset is released, no out_valid appears until 168 cycles after the next accepted element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks in_elem as an element to invert |
| in_elem | input | 113 | Field element in polynomial basis |
| out_valid | output | 1 | Marks out_inv as a finished inverse |
| out_inv | output | 113 | Inverse of the element accepted 168 cycles earlier |

## Verification
The assertions check four things on every cycle:
- The output stays quiet for the full latency after reset.
- The count of elements in flight never exceeds the pipeline depth, and it is nonzero whenever a result appears.
- Each squarer maps 1 to 1.
- Each multiplier passes its second operand through unchanged when the first operand is 1.

Only the bench scenarios can show the arithmetic itself: that each result really inverts its own input, and that this still holds across back-to-back streams, sparse streams, zero inputs, the known values for 1 and x, and a reset taken with data in flight.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    localparam int FIELD_M = 113;
    // Low-order terms of the reduction polynomial: x^5 + x^3 + x^2 + 1
    localparam logic [FIELD_M-1:0] FIELD_RED = 113'h2D;

    typedef logic [FIELD_M-1:0]   gf_t;
    typedef logic [2*FIELD_M-2:0] gf_wide_t;

    // Fold every term of degree >= M back into the low M bits.
    function automatic gf_t gf_reduce(input gf_wide_t w);
        gf_wide_t t;
        t = w;
        for (int i = 2*FIELD_M-2; i >= FIELD_M; i--) begin
            if (t[i]) begin
                t[i] = 1'b0;
                t[i-FIELD_M +: FIELD_M] = t[i-FIELD_M +: FIELD_M] ^ FIELD_RED;
            end
        end
        return t[FIELD_M-1:0];
    endfunction

    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_wide_t acc;
        acc = '0;
        for (int i = 0; i < FIELD_M; i++) begin
            if (b[i]) acc = acc ^ (gf_wide_t'(a) << i);
        end
        return gf_reduce(acc);
    endfunction

    // Squaring spreads the bits apart with zeros, then reduces.
    function automatic gf_t gf_sq(input gf_t a);
        gf_wide_t acc;
        acc = '0;
        for (int i = 0; i < FIELD_M; i++) acc[2*i] = a[i];
        return gf_reduce(acc);
    endfunction

    function automatic int msb_pos(input int v);
        int p;
        p = 0;
        for (int i = 0; i < 31; i++) begin
            if (((v >> i) & 1) != 0) p = i;
        end
        return p;
    endfunction

    // Chain steps scan the bits of (m-1) below its MSB:
    // each bit gives a doubling step, and a one bit adds an increment step.
    function automatic int chain_steps(input int m);
        int e;
        int n;
        e = m - 1;
        n = 0;
        for (int b = msb_pos(e) - 1; b >= 0; b--) begin
            n = n + 1;
            if (((e >> b) & 1) != 0) n = n + 1;
        end
        return n;
    endfunction

    // Number of squarings in step idx.
    function automatic int step_sq(input int m, input int idx);
        int e;
        int n;
        int k;
        int res;
        e = m - 1;
        n = 0;
        k = 1;
        res = 0;
        for (int b = msb_pos(e) - 1; b >= 0; b--) begin
            if (n == idx) res = k;
            n = n + 1;
            k = 2 * k;
            if (((e >> b) & 1) != 0) begin
                if (n == idx) res = 1;
                n = n + 1;
                k = k + 1;
            end
        end
        return res;
    endfunction

    // 1 when step idx multiplies by the original element.
    function automatic bit step_inc(input int m, input int idx);
        int e;
        int n;
        bit res;
        e = m - 1;
        n = 0;
        res = 1'b0;
        for (int b = msb_pos(e) - 1; b >= 0; b--) begin
            n = n + 1;
            if (((e >> b) & 1) != 0) begin
                if (n == idx) res = 1'b1;
                n = n + 1;
            end
        end
        return res;
    endfunction

    // Cycles from the block input to the input of step idx.
    function automatic int step_offset(input int m, input int lat, input int idx);
        int s;
        s = 0;
        for (int j = 0; j < idx; j++) s = s + step_sq(m, j) + lat;
        return s;
    endfunction

    function automatic int total_latency(input int m, input int lat);
        return step_offset(m, lat, chain_steps(m)) + 1;
    endfunction

endpackage

// File: rtl/gf_delay.sv
module gf_delay #(
    parameter int W     = 113,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] d_q [DEPTH];

    always_ff @(posedge clk) begin
        d_q[0] <= din;
        for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
    end

    assign dout = d_q[DEPTH-1];

endmodule

// File: rtl/gf_sq_chain.sv
module gf_sq_chain import gfinv_pkg::*; #(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_v,
    input  gf_t  in_x,
    output logic out_v,
    output gf_t  out_x
);

    gf_t              x_q [DEPTH];
    logic [DEPTH-1:0] v_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q[0] <= in_v;
            for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
        end
    end

    // One squaring per register stage.
    always_ff @(posedge clk) begin
        x_q[0] <= gf_sq(in_x);
        for (int i = 1; i < DEPTH; i++) x_q[i] <= gf_sq(x_q[i-1]);
    end

    assign out_v = v_q[DEPTH-1];
    assign out_x = x_q[DEPTH-1];

    // R5
    sq_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && in_x == gf_t'(1)) |=> (x_q[0] == gf_t'(1)));

endmodule

// File: rtl/gf_mul_pipe.sv
module gf_mul_pipe import gfinv_pkg::*; #(
    parameter int LAT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_v,
    input  gf_t  in_a,
    input  gf_t  in_b,
    output logic out_v,
    output gf_t  out_p
);

    localparam int TAIL = LAT - 1;

    logic            s_v;
    gf_t             s_a;
    gf_t             s_b;
    gf_t             prod_c;
    gf_t             p_q [TAIL];
    logic [TAIL-1:0] pv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_v  <= 1'b0;
            pv_q <= '0;
        end else begin
            s_v     <= in_v;
            pv_q[0] <= s_v;
            for (int i = 1; i < TAIL; i++) pv_q[i] <= pv_q[i-1];
        end
    end

    assign prod_c = gf_mul(s_a, s_b);

    always_ff @(posedge clk) begin
        s_a    <= in_a;
        s_b    <= in_b;
        p_q[0] <= prod_c;
        for (int i = 1; i < TAIL; i++) p_q[i] <= p_q[i-1];
    end

    assign out_v = pv_q[TAIL-1];
    assign out_p = p_q[TAIL-1];

    // R3
    mul_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_v && s_a == gf_t'(1)) |=> (p_q[0] == $past(s_b)));

endmodule

// File: rtl/itoh_step.sv
module itoh_step import gfinv_pkg::*; #(
    parameter int SQ      = 1,
    parameter int MUL_LAT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_v,
    input  gf_t  in_x,
    input  gf_t  in_y,
    output logic out_v,
    output gf_t  out_x
);

    logic sq_v;
    gf_t  sq_x;
    gf_t  y_d;

    gf_sq_chain #(.DEPTH(SQ)) u_sq (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (in_v),
        .in_x  (in_x),
        .out_v (sq_v),
        .out_x (sq_x)
    );

    // Hold the second operand while the squarings run.
    gf_delay #(.W(FIELD_M), .DEPTH(SQ)) u_ydly (
        .clk  (clk),
        .din  (in_y),
        .dout (y_d)
    );

    gf_mul_pipe #(.LAT(MUL_LAT)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (sq_v),
        .in_a  (sq_x),
        .in_b  (y_d),
        .out_v (out_v),
        .out_p (out_x)
    );

endmodule

// File: rtl/gf113_inverter.sv
module gf113_inverter import gfinv_pkg::*; #(
    parameter int MUL_LAT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [FIELD_M-1:0] in_elem,
    output logic               out_valid,
    output logic [FIELD_M-1:0] out_inv
);

    localparam int NSTEPS    = chain_steps(FIELD_M);
    localparam int TOTAL_LAT = total_latency(FIELD_M, MUL_LAT);
    localparam int CW        = $clog2(TOTAL_LAT + 1) + 1;

    gf_t         st_x [NSTEPS+1];
    logic [NSTEPS:0] st_v;

    assign st_x[0] = in_elem;
    assign st_v[0] = in_valid;

    for (genvar i = 0; i < NSTEPS; i++) begin : g_step
        localparam int SQ = step_sq(FIELD_M, i);
        gf_t y;

        if (step_inc(FIELD_M, i)) begin : g_inc
            // Original element, aligned with the input of this step.
            gf_delay #(.W(FIELD_M), .DEPTH(step_offset(FIELD_M, MUL_LAT, i))) u_adly (
                .clk  (clk),
                .din  (in_elem),
                .dout (y)
            );
        end else begin : g_dbl
            assign y = st_x[i];
        end

        itoh_step #(.SQ(SQ), .MUL_LAT(MUL_LAT)) u_step (
            .clk   (clk),
            .rst_n (rst_n),
            .in_v  (st_v[i]),
            .in_x  (st_x[i]),
            .in_y  (y),
            .out_v (st_v[i+1]),
            .out_x (st_x[i+1])
        );
    end

    // a^(2^(m-1) - 1) squared once more gives a^(2^m - 2).
    gf_sq_chain #(.DEPTH(1)) u_final (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (st_v[NSTEPS]),
        .in_x  (st_x[NSTEPS]),
        .out_v (out_valid),
        .out_x (out_inv)
    );

    // Occupancy tracking for the checks below.
    logic [CW-1:0] since_rst;
    logic [CW-1:0] inflight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            inflight  <= '0;
        end else begin
            if (since_rst < CW'(TOTAL_LAT)) since_rst <= since_rst + CW'(1);
            inflight <= inflight + CW'(in_valid) - CW'(out_valid);
        end
    end

    // R9
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < CW'(TOTAL_LAT)) |-> !out_valid);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CW'(TOTAL_LAT));

    // R2
    out_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight != '0));

endmodule

// File: tb/gf113_inverter_test.sv
`timescale 1ns/1ps
module gf113_inverter_test;

    localparam int LAT = 168;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [112:0] in_elem = '0;
    logic         out_valid;
    logic [112:0] out_inv;

    int total = 0;
    int bad = 0;
    int sent = 0;
    int results = 0;
    bit finished = 1'b0;
    string phase = "R1";

    typedef struct packed {
        logic         v;
        logic [112:0] d;
    } ent_t;
    ent_t hist[$];

    always #2.5 clk = ~clk;

    gf113_inverter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_elem   (in_elem),
        .out_valid (out_valid),
        .out_inv   (out_inv)
    );

    // Reference arithmetic: MSB-first shift-and-add multiply.
    function automatic logic [112:0] ref_mul(input logic [112:0] a, input logic [112:0] b);
        logic [112:0] r;
        logic [113:0] t;
        r = '0;
        for (int i = 112; i >= 0; i--) begin
            t = {r, 1'b0};
            if (t[113]) t = t ^ {1'b1, 113'h2D};
            r = t[112:0];
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [112:0] rnd_elem();
        logic [127:0] r;
        r = {$urandom, $urandom, $urandom, $urandom};
        if (r[112:0] == '0) r[0] = 1'b1;
        return r[112:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [112:0] act, input logic [112:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle model, evaluated away from the clock edge.
    always @(negedge clk) begin
        #1;
        if (!finished) begin
            if (!rst_n) begin
                chk(out_valid == 1'b0, "R9", "valid during reset", 113'(out_valid), 113'd0);
                hist.delete();
                hist.push_back('{v: 1'b0, d: '0});
            end else begin
                ent_t e;
                e = '0;
                if (hist.size() == LAT) e = hist.pop_front();
                chk(out_valid == e.v, phase, "valid timing", 113'(out_valid), 113'(e.v));
                if (e.v && out_valid) begin
                    results++;
                    if (e.d == '0) begin
                        chk(1'b1, "R7", "zero element valid", 113'(out_valid), 113'd1);
                    end else begin
                        chk(ref_mul(e.d, out_inv) == 113'd1, "R3", "product", ref_mul(e.d, out_inv), 113'd1);
                    end
                    if (e.d == 113'd1)
                        chk(out_inv == 113'd1, "R5", "inverse of 1", out_inv, 113'd1);
                    if (e.d == 113'd2)
                        chk(out_inv == ((113'd1 << 112) | 113'h16), "R8", "inverse of x",
                            out_inv, (113'd1 << 112) | 113'h16);
                end
                hist.push_back('{v: in_valid, d: in_elem});
            end
        end
    end

    task automatic drive(input bit v, input logic [112:0] d);
        @(negedge clk);
        in_valid = v;
        in_elem  = d;
        if (v) sent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, '0);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", results, sent);
        summary();
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle output after reset
        phase = "R1";
        idle(200);

        phase = "R2";
        drive(1'b1, 113'd1);
        idle(3);
        drive(1'b1, 113'd2);
        idle(180);

        // R4: back-to-back stream
        phase = "R4";
        sent = 0;
        results = 0;
        for (int i = 0; i < 300; i++) drive(1'b1, rnd_elem());
        idle(180);
        chk(results == sent, "R4", "result count", 113'(results), 113'(sent));

        // R6: sparse stream with gaps
        phase = "R6";
        for (int i = 0; i < 200; i++) drive((i % 3) == 0, rnd_elem());
        idle(180);

        // R7: zero element inside a stream
        phase = "R7";
        drive(1'b1, rnd_elem());
        drive(1'b1, '0);
        drive(1'b1, rnd_elem());
        idle(180);

        // R9: reset with elements in flight
        phase = "R9";
        for (int i = 0; i < 50; i++) drive(1'b1, rnd_elem());
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        sent = 0;
        results = 0;
        idle(200);
        chk(results == 0, "R9", "no stale results", 113'(results), 113'd0);
        for (int i = 0; i < 20; i++) drive(1'b1, rnd_elem());
        idle(180);
        chk(results == sent, "R9", "results after reset", 113'(results), 113'(sent));

        summary();
    end

endmodule